// File: doc/BRIEF.md
# Low-Activity Increment-Decrement Accumulator

This block sums a stream of signed 3-bit correlator summands into a 16-bit running total and hands the total out once per code period when a dump strobe arrives. It is intended for correlator channels that run at the sample rate. When tracking is good, the sum keeps moving in one direction, so the upper bits of a conventional adder loop toggle far more than they need to.

Only the three low bits go through a real adder with a registered result. A small encoder looks at the summand's sign and at the adder's carry out. From these it decides whether the upper 13 bits must count up one step, count down one step, or stay as they are. The upper bits are a chain of single-bit cells. A step command enters at the lowest cell and climbs only as far as carries or borrows require. Most summands therefore touch no upper cell at all.

A dump captures the full 16-bit total, including any summand presented in the same cycle, and restarts the sum from zero. A running count of toggled upper cells is brought out, so that the switching activity can be observed.

Top module: `idd_accum`

## Requirements
- R1: After reset, `sum_out` is 0, `sum_vld` is 0 and `tog_cnt` is 0.
- R2: A dump captures into `sum_out` the 16-bit two's-complement sum, wrapping modulo 2^16, of every accepted summand since the previous dump or reset. `sum_vld` is high for exactly the one cycle after the dump edge, and `sum_out` is updated at that same edge.
- R3: A summand whose `smp_vld` is low has no effect on the sum or on `tog_cnt`.
- R4: A summand whose bit 2 is 0 (non-negative) counts the upper 13 bits up by one exactly when the unsigned 3-bit addition of the low field and the summand carries out.
- R5: A summand whose bit 2 is 1 (negative) counts the upper 13 bits down by one exactly when that unsigned 3-bit addition does not carry out.
- R6: When neither R4 nor R5 issues a step, no upper cell changes and `tog_cnt` stays the same.
- R7: Each step flips exactly the cells from the lowest one up to and including the first cell that does not carry (up) or borrow (down). The top cell passes nothing on, so 0xFFFF + 1 gives 0 with all 13 upper cells flipped. `tog_cnt` grows by the number of flipped cells and wraps modulo 2^16.
- R8: When a dump and an accepted summand arrive in the same cycle, the captured total includes that summand, and the accumulation restarts from zero after the dump.
- R9: Between dumps, `sum_out` holds its last captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Summand strobe |
| smp_val | input | 3 | Signed two's-complement summand |
| dump | input | 1 | End-of-period capture and clear |
| sum_out | output | 16 | Captured 16-bit total |
| sum_vld | output | 1 | One-cycle pulse after a dump |
| tog_cnt | output | 16 | Running count of upper-cell flips |

## Verification
The properties assume that `smp_val` carries a meaningful value only while `smp_vld` is high. They also assume that `dump` may coincide with a summand but never replaces the summand strobe. The stimulus drives both inputs on the falling edge and returns `smp_vld` low between directed summands. It also parks non-zero values on `smp_val` while `smp_vld` is low, to show those values are ignored. Long mixed runs move the sum across zero and through 0xFFFF, so that both the borrow chain and the carry chain climb to the top cell.

// File: rtl/idd_pkg.sv
package idd_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_INC  = 2'b01,
    CMD_DEC  = 2'b10
  } step_cmd_e;
endpackage

// File: rtl/lo_accum.sv
// Low field: narrow adder with registered feedback, exposes carry out.
module lo_accum #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         add_en,
  input  logic [W-1:0] summand,
  input  logic         clr,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] lo_upd,
  output logic         carry
);
  logic [W:0]   raw_sum;
  logic         lo_en;
  logic [W-1:0] lo_d;

  always_comb begin
    raw_sum = {1'b0, lo_q} + {1'b0, summand};
    lo_upd  = add_en ? raw_sum[W-1:0] : lo_q;
    carry   = add_en & raw_sum[W];
    lo_en   = add_en | clr;
    lo_d    = clr ? '0 : lo_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end
endmodule

// File: rtl/step_encoder.sv
// Chooses the command for the upper field from summand sign and low carry.
module step_encoder
  import idd_pkg::*;
(
  input  logic      valid,
  input  logic      sign,
  input  logic      carry,
  output step_cmd_e cmd
);
  always_comb begin
    cmd = CMD_NONE;
    if (valid) begin
      if (!sign && carry)      cmd = CMD_INC;
      else if (sign && !carry) cmd = CMD_DEC;
    end
  end
endmodule

// File: rtl/cnt_cell.sv
// One bit of the upper field; flips on any step that reaches it.
module cnt_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output logic q,
  output logic q_upd
);
  logic flip;
  logic cell_en;
  logic q_d;

  always_comb begin
    flip    = inc | dec;
    q_upd   = q ^ flip;
    cell_en = flip | clr;
    q_d     = clr ? 1'b0 : q_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (cell_en) q <= q_d;
  end
endmodule

// File: rtl/idd_chain.sv
// Chain of cells; a step climbs only while cells carry or borrow.
module idd_chain
  import idd_pkg::*;
#(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  step_cmd_e    cmd,
  input  logic         clr,
  output logic [N-1:0] hi_q,
  output logic [N-1:0] hi_upd
);
  logic [N-1:0] inc_c;
  logic [N-1:0] dec_c;

  assign inc_c[0] = (cmd == CMD_INC);
  assign dec_c[0] = (cmd == CMD_DEC);

  for (genvar i = 0; i < N; i++) begin : g_cell
    cnt_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_c[i]),
      .dec   (dec_c[i]),
      .clr   (clr),
      .q     (hi_q[i]),
      .q_upd (hi_upd[i])
    );
    if (i < N-1) begin : g_pass
      assign inc_c[i+1] = inc_c[i] & hi_q[i];
      assign dec_c[i+1] = dec_c[i] & ~hi_q[i];
    end
  end
endmodule

// File: rtl/idd_accum.sv
module idd_accum
  import idd_pkg::*;
#(
  parameter int LO_W  = 3,
  parameter int HI_W  = 13,
  parameter int TOG_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic [LO_W-1:0]      smp_val,
  input  logic                 dump,
  output logic [LO_W+HI_W-1:0] sum_out,
  output logic                 sum_vld,
  output logic [TOG_W-1:0]     tog_cnt
);
  localparam int SUM_W = LO_W + HI_W;
  localparam int POP_W = $clog2(HI_W + 1);

  logic [LO_W-1:0]  lo_q;
  logic [LO_W-1:0]  lo_upd;
  logic             lo_carry;
  logic [HI_W-1:0]  hi_q;
  logic [HI_W-1:0]  hi_upd;
  step_cmd_e        step_cmd;
  logic [HI_W-1:0]  flips;
  logic [POP_W-1:0] flip_cnt;
  logic             tog_en;
  logic [TOG_W-1:0] tog_d;
  logic [SUM_W-1:0] sum_d;

  lo_accum #(.W(LO_W)) u_lo (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (smp_vld),
    .summand (smp_val),
    .clr     (dump),
    .lo_q    (lo_q),
    .lo_upd  (lo_upd),
    .carry   (lo_carry)
  );

  step_encoder u_enc (
    .valid (smp_vld),
    .sign  (smp_val[LO_W-1]),
    .carry (lo_carry),
    .cmd   (step_cmd)
  );

  idd_chain #(.N(HI_W)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (step_cmd),
    .clr    (dump),
    .hi_q   (hi_q),
    .hi_upd (hi_upd)
  );

  always_comb begin
    flips    = hi_q ^ hi_upd;
    flip_cnt = '0;
    for (int k = 0; k < HI_W; k++) flip_cnt = flip_cnt + POP_W'(flips[k]);
    tog_en   = |flips;
    tog_d    = tog_cnt + TOG_W'(flip_cnt);
    sum_d    = {hi_upd, lo_upd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_cnt <= '0;
    else if (tog_en) tog_cnt <= tog_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sum_out <= '0;
    else if (dump) sum_out <= sum_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_vld <= 1'b0;
    else        sum_vld <= dump;
  end
endmodule

// File: rtl/idd_accum_chk.sv
module idd_accum_chk #(
  parameter int LO_W  = 3,
  parameter int HI_W  = 13,
  parameter int TOG_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_vld,
  input logic [LO_W-1:0]      smp_val,
  input logic                 dump,
  input logic [LO_W+HI_W-1:0] sum_out,
  input logic                 sum_vld,
  input logic [TOG_W-1:0]     tog_cnt,
  input logic [1:0]           cmd,
  input logic [HI_W-1:0]      hi_q,
  input logic [LO_W-1:0]      lo_q
);
  // R2: one-cycle pulse following each dump
  p_vld_after_dump_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> sum_vld);
  p_vld_only_after_dump_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dump |=> !sum_vld);
  // R9: captured value holds outside the capture cycle
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_vld |-> $stable(sum_out));
  // R4: up-steps only for accepted non-negative summands
  p_inc_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01) |-> (smp_vld && !smp_val[LO_W-1]));
  // R5: down-steps only for accepted negative summands
  p_dec_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b10) |-> (smp_vld && smp_val[LO_W-1]));
  // R6: without a step the upper cells and the flip count stay put
  p_hi_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b00 && !dump) |=> $stable(hi_q));
  p_tog_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b00) |=> $stable(tog_cnt));
  // R3: a summand without strobe leaves the low field alone
  p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !dump) |=> $stable(lo_q));
  // R8: the whole sum restarts from zero after a dump
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> (hi_q == '0 && lo_q == '0));
endmodule

bind idd_accum idd_accum_chk #(
  .LO_W  (LO_W),
  .HI_W  (HI_W),
  .TOG_W (TOG_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .smp_vld (smp_vld),
  .smp_val (smp_val),
  .dump    (dump),
  .sum_out (sum_out),
  .sum_vld (sum_vld),
  .tog_cnt (tog_cnt),
  .cmd     (step_cmd),
  .hi_q    (hi_q),
  .lo_q    (lo_q)
);

// File: tb/sim_idd_accum.sv
`timescale 1ns/1ps
module sim_idd_accum;
  logic        clk;
  logic        rst_n;
  logic        smp_vld;
  logic [2:0]  smp_val;
  logic        dump;
  logic [15:0] sum_out;
  logic        sum_vld;
  logic [15:0] tog_cnt;

  int n_chk;
  int n_fail;
  logic [15:0] ms;
  logic [15:0] et;

  idd_accum u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .smp_val (smp_val),
    .dump    (dump),
    .sum_out (sum_out),
    .sum_vld (sum_vld),
    .tog_cnt (tog_cnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int pop13(input logic [12:0] v);
    int c = 0;
    for (int k = 0; k < 13; k++) c += int'(v[k]);
    return c;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // one summand, then check the flip count against the model
  task automatic put(input logic [2:0] v, input logic en, input string req);
    logic [15:0] old;
    smp_vld = en;
    smp_val = v;
    @(posedge clk);
    @(negedge clk);
    smp_vld = 1'b0;
    if (en) begin
      old = ms;
      ms  = ms + {{13{v[2]}}, v};
      et  = et + 16'(pop13(old[15:3] ^ ms[15:3]));
    end
    chk(req, tog_cnt, et);
  endtask

  task automatic dmp(input logic with_smp, input logic [2:0] v, input string req);
    logic [15:0] old;
    logic [15:0] expv;
    dump    = 1'b1;
    smp_vld = with_smp;
    smp_val = v;
    @(posedge clk);
    @(negedge clk);
    dump    = 1'b0;
    smp_vld = 1'b0;
    if (with_smp) begin
      old = ms;
      ms  = ms + {{13{v[2]}}, v};
      et  = et + 16'(pop13(old[15:3] ^ ms[15:3]));
    end
    expv = ms;
    ms   = '0;
    chk({req, " R2 vld"}, {15'd0, sum_vld}, 16'd1);
    chk({req, " R2 sum"}, sum_out, expv);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R2 vld drop"}, {15'd0, sum_vld}, 16'd0);
  endtask

  task automatic t_reset();
    chk("R1 sum", sum_out, 16'd0);
    chk("R1 vld", {15'd0, sum_vld}, 16'd0);
    chk("R1 tog", tog_cnt, 16'd0);
  endtask

  task automatic t_up_run();
    for (int i = 0; i < 20; i++) put(3'd3, 1'b1, "R4 R7 up run");
    dmp(1'b0, 3'd0, "R4 up total 60");
  endtask

  task automatic t_down_run();
    for (int i = 0; i < 5; i++) put(3'b100, 1'b1, "R5 R7 down run");
    dmp(1'b0, 3'd0, "R5 down total -20");
  endtask

  task automatic t_ignore();
    logic [15:0] t0;
    t0 = tog_cnt;
    for (int i = 0; i < 6; i++) put(3'b011 + 3'(i), 1'b0, "R3 no strobe");
    chk("R3 tog unchanged", tog_cnt, t0);
    dmp(1'b0, 3'd0, "R3 zero total");
  endtask

  task automatic t_no_cmd();
    logic [15:0] t0;
    put(3'd1, 1'b1, "R6 +1 no carry");
    t0 = tog_cnt;
    put(3'd0, 1'b1, "R6 zero");
    put(3'd2, 1'b1, "R6 +2 no carry");
    put(3'b111, 1'b1, "R6 -1 with carry");
    chk("R6 tog flat", tog_cnt, t0);
    dmp(1'b0, 3'd0, "R6 total 2");
  endtask

  task automatic t_wrap();
    logic [15:0] t0;
    t0 = tog_cnt;
    put(3'b111, 1'b1, "R7 borrow to top");
    chk("R7 full borrow flips 13", tog_cnt, t0 + 16'd13);
    put(3'd1, 1'b1, "R7 carry to top");
    chk("R7 full carry flips 13", tog_cnt, t0 + 16'd26);
    dmp(1'b0, 3'd0, "R7 wrap total 0");
  endtask

  task automatic t_coincide();
    put(3'd2, 1'b1, "R8 pre");
    dmp(1'b1, 3'd3, "R8 dump with summand");
    dmp(1'b0, 3'd0, "R8 restart zero");
  endtask

  task automatic t_hold();
    put(3'd3, 1'b1, "R9 pre");
    dmp(1'b0, 3'd0, "R9 capture");
    for (int i = 0; i < 4; i++) put(3'd3, 1'b1, "R9 run");
    chk("R9 hold", sum_out, 16'd3);
    dmp(1'b0, 3'd0, "R9 next");
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 400; i++)
      put(3'(i * 5 + 3), (i % 3) != 2, "R2 R7 mixed");
    dmp(1'b1, 3'b101, "R2 R8 mixed total");
    for (int i = 0; i < 300; i++)
      put(3'(i * 3 + 4), 1'b1, "R2 R5 drift down");
    dmp(1'b0, 3'd0, "R2 R5 down total");
  endtask

  initial begin
    n_chk   = 0;
    n_fail  = 0;
    ms      = '0;
    et      = '0;
    rst_n   = 1'b0;
    smp_vld = 1'b0;
    smp_val = 3'd0;
    dump    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up_run();
    t_down_run();
    t_ignore();
    t_no_cmd();
    t_wrap();
    t_coincide();
    t_hold();
    t_mixed();
    finish_run();
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule